// File: doc/BRIEF.md
# Masked-Page Translation Lookaside Buffer

This block is a small, fully associative translation cache. Each slot holds a virtual page number, a per-slot ignore mask over that page number, an address-space tag, a global flag, two valid flags and a physical frame number. Every slot is compared in parallel. A mask bit set to one removes that page-number bit from the compare, so one slot can cover a larger page. A set global flag makes the slot answer for any address-space tag.

Four operations share the table. A lookup takes a full virtual address and answers hit and frame one cycle later. A probe takes a page number and answers the slot index. An indexed write fills one slot. A flush empties the whole table. A round-robin pointer can be read and optionally advanced, which gives software a victim slot. The lookup path also flags instruction fetches that are not word aligned, and addresses in the uncacheable window.

Top module: `tlb_mp_top`

## Requirements
- R1: A slot matches only where the requested page number equals the stored one on every bit whose stored mask bit is 0. Bits whose mask bit is 1 are not compared.
- R2: A slot's address-space tag must equal the requested tag, unless the slot's global flag is 1. With the flag set, any tag matches.
- R3: A lookup presented with `lk_valid` in cycle n gives `lk_done`=1, `lk_hit` and `lk_pfn` in cycle n+1. When several slots match, the lowest index supplies the frame. `lk_pfn` is 0 on a miss.
- R4: A probe returns `pr_result` one cycle later. The value is the lowest matching slot index, zero-extended, or all ones (15 with 8 slots) when nothing matches.
- R5: A slot is occupied when either of its valid flags is 1. A slot with both flags at 0 never matches, whatever its other fields hold.
- R6: A write with `wr_index` below the slot count replaces that slot. A write at or above the slot count leaves every slot unchanged and pulses `wr_oor` in the next cycle.
- R7: `flush` empties every slot, clearing both valid flags, and returns the replacement pointer to 0. Flush takes priority over a write or an advance in the same cycle.
- R8: A pointer read (`rd_req`) returns, one cycle later, the pointer value and that slot's page number, frame and occupancy. The pointer moves on by one only when `rd_adv` is 1.
- R9: The replacement pointer wraps from the last slot index to 0.
- R10: A lookup with `lk_inst`=1 whose address has either bit 1 or bit 0 set raises `lk_align_fault`. It reports `lk_hit`=0 and `lk_pfn`=0.
- R11: A lookup whose address has both bit 31 and bit 29 set (all bits of 0xA0000000) raises `lk_uncache`.
- R12: After reset every slot is empty, the pointer is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the table and return the pointer to 0 |
| wr_en | input | 1 | Write strobe |
| wr_index | input | IDX_W+1 | Slot to write; may be out of range |
| wr_vpn | input | VPN_W | Page number to store |
| wr_mask | input | VPN_W | Ignore mask to store (1 = bit not compared) |
| wr_asid | input | ASID_W | Address-space tag to store |
| wr_global | input | 1 | Global flag to store |
| wr_v0 | input | 1 | First valid flag |
| wr_v1 | input | 1 | Second valid flag |
| wr_pfn | input | PFN_W | Frame number to store |
| wr_oor | output | 1 | Pulse: the previous write was out of range |
| lk_valid | input | 1 | Lookup strobe |
| lk_va | input | VA_W | Lookup virtual address; page number is its top VPN_W bits |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_inst | input | 1 | Lookup is an instruction fetch |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number of the hit |
| lk_align_fault | output | 1 | Misaligned instruction fetch |
| lk_uncache | output | 1 | Address lies in the uncacheable window |
| pr_valid | input | 1 | Probe strobe |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe address-space tag |
| pr_done | output | 1 | Probe result valid |
| pr_result | output | IDX_W+1 | Matching index, or all ones on a miss |
| rd_req | input | 1 | Read the slot at the pointer |
| rd_adv | input | 1 | Advance the pointer after this read |
| rd_done | output | 1 | Pointer read result valid |
| rd_index | output | IDX_W | Pointer value that was read |
| rd_vpn | output | VPN_W | Page number of that slot |
| rd_pfn | output | PFN_W | Frame of that slot |
| rd_occupied | output | 1 | That slot is occupied |

## Verification
A slot whose stored mask, tag or valid flags went wrong shows up as a wrong hit, a wrong frame or a wrong probe index. It appears on the first lookup or probe that reaches that slot, one cycle after the request. Shadowing between overlapping slots is exposed by writing several slots that match the same page. The probe index then names exactly which slot won. A pointer that drifted, missed its wrap or survived a flush appears in `rd_index` on the next pointer read. Random traffic with a narrow page-number range keeps matches, overlaps and misses all frequent.

// File: rtl/tlb_mp_pkg.sv
package tlb_mp_pkg;

   // Window of addresses treated as not cacheable: every set bit must be set.
   localparam logic [31:0] UNCACHED_WINDOW = 32'hA000_0000;

   // Instruction fetches must be aligned to this many low address bits.
   localparam int FETCH_ALIGN_BITS = 2;

   function automatic logic in_uncached_window(input logic [31:0] va);
      return (va & UNCACHED_WINDOW) == UNCACHED_WINDOW;
   endfunction

endpackage

// File: rtl/tlb_mp_store.sv
// Slot storage with flush, indexed write and two parallel match ports.
module tlb_mp_store #(
   parameter int N      = 8,
   parameter int WIDX_W = 4,
   parameter int VPN_W  = 20,
   parameter int PFN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush,
   input  logic                        wr_en,
   input  logic [WIDX_W-1:0]           wr_idx,
   input  logic [VPN_W-1:0]            wr_vpn,
   input  logic [VPN_W-1:0]            wr_mask,
   input  logic [ASID_W-1:0]           wr_asid,
   input  logic                        wr_global,
   input  logic                        wr_v0,
   input  logic                        wr_v1,
   input  logic [PFN_W-1:0]            wr_pfn,
   input  logic [VPN_W-1:0]            qa_vpn,
   input  logic [ASID_W-1:0]           qa_asid,
   input  logic [VPN_W-1:0]            qb_vpn,
   input  logic [ASID_W-1:0]           qb_asid,
   output logic [N-1:0]                qa_match,
   output logic [N-1:0]                qb_match,
   output logic [N-1:0]                occ,
   output logic [N-1:0][VPN_W-1:0]     vpn_all,
   output logic [N-1:0][PFN_W-1:0]     pfn_all
);

   logic [N-1:0][VPN_W-1:0]  mask_q;
   logic [N-1:0][ASID_W-1:0] asid_q;
   logic [N-1:0]             glob_q;
   logic [N-1:0]             v0_q;
   logic [N-1:0]             v1_q;

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic sel;
      assign sel = wr_en && !flush && (wr_idx == WIDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vpn_all[i] <= '0;
            mask_q[i]  <= '0;
            asid_q[i]  <= '0;
            glob_q[i]  <= 1'b0;
            v0_q[i]    <= 1'b0;
            v1_q[i]    <= 1'b0;
            pfn_all[i] <= '0;
         end else if (flush) begin
            vpn_all[i] <= '0;
            mask_q[i]  <= '0;
            asid_q[i]  <= '0;
            glob_q[i]  <= 1'b0;
            v0_q[i]    <= 1'b0;
            v1_q[i]    <= 1'b0;
            pfn_all[i] <= '0;
         end else if (sel) begin
            vpn_all[i] <= wr_vpn;
            mask_q[i]  <= wr_mask;
            asid_q[i]  <= wr_asid;
            glob_q[i]  <= wr_global;
            v0_q[i]    <= wr_v0;
            v1_q[i]    <= wr_v1;
            pfn_all[i] <= wr_pfn;
         end
      end

      assign occ[i] = v0_q[i] | v1_q[i];

      assign qa_match[i] = occ[i]
                         && (((qa_vpn ^ vpn_all[i]) & ~mask_q[i]) == '0)
                         && (glob_q[i] || (asid_q[i] == qa_asid));
      assign qb_match[i] = occ[i]
                         && (((qb_vpn ^ vpn_all[i]) & ~mask_q[i]) == '0)
                         && (glob_q[i] || (asid_q[i] == qb_asid));
   end

endmodule

// File: rtl/tlb_mp_prio.sv
// Lowest-index-first selector.
module tlb_mp_prio #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/tlb_mp_rptr.sv
// Round-robin replacement pointer.
module tlb_mp_rptr #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);

   logic [IDX_W-1:0] nxt;

   if (N == (1 << IDX_W)) begin : g_pow2
      // Natural roll-over supplies the wrap.
      assign nxt = ptr + 1'b1;
   end else begin : g_cmp
      assign nxt = (ptr == IDX_W'(N - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (flush) ptr <= '0;
      else if (adv)   ptr <= nxt;
   end

endmodule

// File: rtl/tlb_mp_top.sv
module tlb_mp_top #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int VA_W    = 32,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int WIDX_W = IDX_W + 1,
   localparam int PR_W   = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_index,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [VPN_W-1:0]  wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_global,
   input  logic              wr_v0,
   input  logic              wr_v1,
   input  logic [PFN_W-1:0]  wr_pfn,
   output logic              wr_oor,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_inst,
   output logic              lk_done,
   output logic              lk_hit,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic              lk_align_fault,
   output logic              lk_uncache,
   input  logic              pr_valid,
   input  logic [VPN_W-1:0]  pr_vpn,
   input  logic [ASID_W-1:0] pr_asid,
   output logic              pr_done,
   output logic [PR_W-1:0]   pr_result,
   input  logic              rd_req,
   input  logic              rd_adv,
   output logic              rd_done,
   output logic [IDX_W-1:0]  rd_index,
   output logic [VPN_W-1:0]  rd_vpn,
   output logic [PFN_W-1:0]  rd_pfn,
   output logic              rd_occupied
);
   import tlb_mp_pkg::*;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_mp_top: ENTRIES must be at least 2");
   end
   if (VA_W != 32) begin : g_bad_va
      $error("tlb_mp_top: VA_W must be 32");
   end
   if (VPN_W < 1 || VPN_W > VA_W - FETCH_ALIGN_BITS) begin : g_bad_vpn
      $error("tlb_mp_top: VPN_W must leave the fetch alignment bits below it");
   end

   logic [ENTRIES-1:0]             lk_match, pr_match, occ_vec;
   logic [ENTRIES-1:0][VPN_W-1:0]  vpn_all;
   logic [ENTRIES-1:0][PFN_W-1:0]  pfn_all;
   logic                           lk_found, pr_found;
   logic [IDX_W-1:0]               lk_idx, pr_idx, rptr;
   logic [VPN_W-1:0]               lk_vpn;
   logic                           misaligned;

   assign lk_vpn     = lk_va[VA_W-1 -: VPN_W];
   assign misaligned = lk_inst && (lk_va[FETCH_ALIGN_BITS-1:0] != '0);

   tlb_mp_store #(
      .N(ENTRIES), .WIDX_W(WIDX_W), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_en), .wr_idx(wr_index), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
      .wr_asid(wr_asid), .wr_global(wr_global), .wr_v0(wr_v0), .wr_v1(wr_v1),
      .wr_pfn(wr_pfn),
      .qa_vpn(lk_vpn), .qa_asid(lk_asid),
      .qb_vpn(pr_vpn), .qb_asid(pr_asid),
      .qa_match(lk_match), .qb_match(pr_match),
      .occ(occ_vec), .vpn_all(vpn_all), .pfn_all(pfn_all)
   );

   tlb_mp_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_lk (
      .req(lk_match), .found(lk_found), .idx(lk_idx)
   );

   tlb_mp_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick_pr (
      .req(pr_match), .found(pr_found), .idx(pr_idx)
   );

   tlb_mp_rptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rptr (
      .clk(clk), .rst_n(rst_n), .flush(flush), .adv(rd_req && rd_adv), .ptr(rptr)
   );

   // Lookup result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_done        <= 1'b0;
         lk_hit         <= 1'b0;
         lk_pfn         <= '0;
         lk_align_fault <= 1'b0;
         lk_uncache     <= 1'b0;
      end else begin
         lk_done        <= lk_valid;
         lk_hit         <= lk_valid && lk_found && !misaligned;
         lk_pfn         <= (lk_valid && lk_found && !misaligned) ? pfn_all[lk_idx] : '0;
         lk_align_fault <= lk_valid && misaligned;
         lk_uncache     <= lk_valid && in_uncached_window(lk_va[31:0]);
      end
   end

   // Probe result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pr_done   <= 1'b0;
         pr_result <= '0;
      end else begin
         pr_done <= pr_valid;
         if (pr_valid) pr_result <= pr_found ? {1'b0, pr_idx} : '1;
      end
   end

   // Pointer read register and write range flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_done     <= 1'b0;
         rd_index    <= '0;
         rd_vpn      <= '0;
         rd_pfn      <= '0;
         rd_occupied <= 1'b0;
         wr_oor      <= 1'b0;
      end else begin
         rd_done <= rd_req;
         if (rd_req) begin
            rd_index    <= rptr;
            rd_vpn      <= vpn_all[rptr];
            rd_pfn      <= pfn_all[rptr];
            rd_occupied <= occ_vec[rptr];
         end
         wr_oor <= wr_en && !flush && (wr_index >= WIDX_W'(ENTRIES));
      end
   end

endmodule

// File: rtl/tlb_mp_chk.sv
module tlb_mp_chk #(
   parameter int N      = 8,
   parameter int IDX_W  = 3,
   parameter int WIDX_W = 4,
   parameter int PR_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              wr_en,
   input logic [WIDX_W-1:0] wr_index,
   input logic              wr_oor,
   input logic              lk_valid,
   input logic              lk_done,
   input logic              lk_hit,
   input logic              lk_align_fault,
   input logic              pr_done,
   input logic [PR_W-1:0]   pr_result,
   input logic              rd_req,
   input logic              rd_adv,
   input logic [IDX_W-1:0]  ptr,
   input logic [N-1:0]      occ
);

   p_done_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_done);

   p_hit_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_done);

   p_align_nohit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_align_fault |-> !lk_hit);

   p_probe_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pr_done |-> (pr_result == '1 || pr_result < PR_W'(N)));

   p_oor_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !flush && wr_index >= WIDX_W'(N)) |=> wr_oor);

   p_oor_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !flush && wr_index >= WIDX_W'(N)) |=> !wr_oor);

   p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0 && ptr == '0));

   p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && !(rd_req && rd_adv)) |=> $stable(ptr));

   p_ptr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && rd_req && rd_adv && ptr == IDX_W'(N - 1)) |=> ptr == '0);

endmodule

bind tlb_mp_top tlb_mp_chk #(
   .N(ENTRIES), .IDX_W(IDX_W), .WIDX_W(WIDX_W), .PR_W(PR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_index(wr_index),
   .wr_oor(wr_oor), .lk_valid(lk_valid), .lk_done(lk_done), .lk_hit(lk_hit),
   .lk_align_fault(lk_align_fault), .pr_done(pr_done), .pr_result(pr_result),
   .rd_req(rd_req), .rd_adv(rd_adv), .ptr(rptr), .occ(occ_vec)
);

// File: tb/tlb_mp_top_test.sv
`timescale 1ns/1ps
module tlb_mp_top_test;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_index = '0;
   logic [19:0] wr_vpn = '0, wr_mask = '0, wr_pfn = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_global = 1'b0, wr_v0 = 1'b0, wr_v1 = 1'b0;
   logic        wr_oor;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_inst = 1'b0;
   logic        lk_done, lk_hit, lk_align_fault, lk_uncache;
   logic [19:0] lk_pfn;
   logic        pr_valid = 1'b0;
   logic [19:0] pr_vpn = '0;
   logic [7:0]  pr_asid = '0;
   logic        pr_done;
   logic [3:0]  pr_result;
   logic        rd_req = 1'b0, rd_adv = 1'b0;
   logic        rd_done, rd_occupied;
   logic [2:0]  rd_index;
   logic [19:0] rd_vpn, rd_pfn;

   always #2 clk = ~clk;

   tlb_mp_top uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_index(wr_index),
      .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_global(wr_global),
      .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_pfn(wr_pfn), .wr_oor(wr_oor),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_inst(lk_inst),
      .lk_done(lk_done), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
      .lk_align_fault(lk_align_fault), .lk_uncache(lk_uncache),
      .pr_valid(pr_valid), .pr_vpn(pr_vpn), .pr_asid(pr_asid), .pr_done(pr_done),
      .pr_result(pr_result), .rd_req(rd_req), .rd_adv(rd_adv), .rd_done(rd_done),
      .rd_index(rd_index), .rd_vpn(rd_vpn), .rd_pfn(rd_pfn), .rd_occupied(rd_occupied)
   );

   // Reference model
   logic [19:0] m_vpn [N];
   logic [19:0] m_mask[N];
   logic [19:0] m_pfn [N];
   logic [7:0]  m_asid[N];
   logic        m_g[N], m_v0[N], m_v1[N];
   int          m_ptr;

   int nchecks = 0;
   int nfail   = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic void model_clear();
      for (int i = 0; i < N; i++) begin
         m_vpn[i] = '0; m_mask[i] = '0; m_pfn[i] = '0; m_asid[i] = '0;
         m_g[i] = 1'b0; m_v0[i] = 1'b0; m_v1[i] = 1'b0;
      end
      m_ptr = 0;
   endfunction

   function automatic int ref_find(input logic [19:0] vpn, input logic [7:0] asid);
      for (int i = 0; i < N; i++) begin
         if ((m_v0[i] || m_v1[i]) && (((vpn ^ m_vpn[i]) & ~m_mask[i]) == '0)
             && (m_g[i] || m_asid[i] == asid))
            return i;
      end
      return -1;
   endfunction

   task automatic do_write(input logic [3:0] idx, input logic [19:0] vpn,
                           input logic [19:0] mask, input logic [7:0] asid,
                           input logic g, input logic v0, input logic v1,
                           input logic [19:0] pfn, input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_index = idx; wr_vpn = vpn; wr_mask = mask; wr_asid = asid;
      wr_global = g; wr_v0 = v0; wr_v1 = v1; wr_pfn = pfn;
      @(negedge clk);
      wr_en = 1'b0;
      check(wr_oor === (idx >= 4'(N)), tag, "wr_oor", 32'(wr_oor), 32'(idx >= 4'(N)));
      if (idx < 4'(N)) begin
         m_vpn[idx] = vpn; m_mask[idx] = mask; m_asid[idx] = asid; m_g[idx] = g;
         m_v0[idx] = v0; m_v1[idx] = v1; m_pfn[idx] = pfn;
      end
   endtask

   task automatic do_lookup(input logic [31:0] va, input logic [7:0] asid,
                            input logic inst, input string tag);
      int f;
      bit mis, ehit, eunc;
      logic [19:0] epfn;
      @(negedge clk);
      lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_inst = inst;
      @(negedge clk);
      lk_valid = 1'b0;
      f    = ref_find(va[31:12], asid);
      mis  = inst && (va[1:0] != 2'b00);
      ehit = (f >= 0) && !mis;
      epfn = ehit ? m_pfn[f] : 20'h0;
      eunc = va[31] && va[29];
      check(lk_done === 1'b1, tag, "lk_done", 32'(lk_done), 32'd1);
      check(lk_hit === ehit, tag, "lk_hit", 32'(lk_hit), 32'(ehit));
      check(lk_pfn === epfn, tag, "lk_pfn", 32'(lk_pfn), 32'(epfn));
      check(lk_align_fault === mis, "R10", "lk_align_fault", 32'(lk_align_fault), 32'(mis));
      check(lk_uncache === eunc, "R11", "lk_uncache", 32'(lk_uncache), 32'(eunc));
   endtask

   task automatic do_probe(input logic [19:0] vpn, input logic [7:0] asid,
                           input string tag);
      int f;
      logic [3:0] exp;
      @(negedge clk);
      pr_valid = 1'b1; pr_vpn = vpn; pr_asid = asid;
      @(negedge clk);
      pr_valid = 1'b0;
      f   = ref_find(vpn, asid);
      exp = (f < 0) ? 4'hF : 4'(f);
      check(pr_done === 1'b1 && pr_result === exp, tag, "pr_result",
            32'(pr_result), 32'(exp));
   endtask

   task automatic do_read(input logic adv, input string tag);
      @(negedge clk);
      rd_req = 1'b1; rd_adv = adv;
      @(negedge clk);
      rd_req = 1'b0; rd_adv = 1'b0;
      check(rd_done === 1'b1 && rd_index === 3'(m_ptr), tag, "rd_index",
            32'(rd_index), 32'(m_ptr));
      check(rd_vpn === m_vpn[m_ptr] && rd_pfn === m_pfn[m_ptr], tag, "rd_vpn",
            32'(rd_vpn), 32'(m_vpn[m_ptr]));
      check(rd_occupied === (m_v0[m_ptr] | m_v1[m_ptr]), tag, "rd_occupied",
            32'(rd_occupied), 32'(m_v0[m_ptr] | m_v1[m_ptr]));
      if (adv) m_ptr = (m_ptr + 1) % N;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      model_clear();
   endtask

   function automatic logic [19:0] pick_vpn();
      logic [19:0] hi;
      hi = ($urandom % 3 == 0) ? 20'hA0000 : 20'h00000;
      return hi | 20'($urandom % 16);
   endfunction

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchecks++;
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      model_clear();
      repeat (3) @(negedge clk);
      // R12: reset state
      check(lk_done === 1'b0 && lk_hit === 1'b0 && lk_pfn === 20'h0, "R12",
            "lookup outputs", 32'(lk_hit), 32'd0);
      check(pr_done === 1'b0 && rd_done === 1'b0 && wr_oor === 1'b0, "R12",
            "other outputs", 32'(wr_oor), 32'd0);
      rst_n = 1'b1;
      do_probe(20'h00000, 8'h00, "R12");
      do_read(1'b0, "R12");

      // R1: masked compare
      do_write(4'd2, 20'h00015, 20'h00003, 8'd5, 1'b0, 1'b1, 1'b0, 20'h12345, "R6");
      do_lookup({20'h00016, 12'h000}, 8'd5, 1'b0, "R1");
      do_lookup({20'h00019, 12'h000}, 8'd5, 1'b0, "R1");
      do_probe(20'h00014, 8'd5, "R1");

      // R2: tag compare and global bypass
      do_lookup({20'h00015, 12'h000}, 8'd6, 1'b0, "R2");
      do_write(4'd5, 20'h00040, 20'h0, 8'd1, 1'b1, 1'b1, 1'b1, 20'h0ABCD, "R6");
      do_lookup({20'h00040, 12'h004}, 8'd9, 1'b0, "R2");
      do_probe(20'h00040, 8'd77, "R2");

      // R3: lowest index wins
      do_write(4'd4, 20'h00100, 20'h0, 8'd3, 1'b0, 1'b1, 1'b0, 20'h44444, "R6");
      do_write(4'd1, 20'h00100, 20'h0, 8'd3, 1'b0, 1'b0, 1'b1, 20'h11111, "R6");
      do_lookup({20'h00100, 12'h000}, 8'd3, 1'b0, "R3");
      do_probe(20'h00100, 8'd3, "R4");
      do_probe(20'h00777, 8'd3, "R4");

      // R5: both valid flags clear never hit
      do_write(4'd6, 20'h00200, 20'h0, 8'd0, 1'b1, 1'b0, 1'b0, 20'h66666, "R6");
      do_lookup({20'h00200, 12'h000}, 8'd0, 1'b0, "R5");
      do_probe(20'h00200, 8'd0, "R5");
      do_write(4'd6, 20'h00200, 20'h0, 8'd0, 1'b1, 1'b0, 1'b1, 20'h66666, "R6");
      do_lookup({20'h00200, 12'h000}, 8'd0, 1'b0, "R5");

      // R6: out-of-range writes change nothing
      do_write(4'd8, 20'h00300, 20'h0, 8'd0, 1'b1, 1'b1, 1'b1, 20'h77777, "R6");
      do_write(4'd15, 20'h00100, 20'h0, 8'd3, 1'b1, 1'b1, 1'b1, 20'h99999, "R6");
      do_probe(20'h00300, 8'd0, "R6");
      do_lookup({20'h00100, 12'h000}, 8'd3, 1'b0, "R6");
      do_write(4'd7, 20'h00300, 20'h0, 8'd0, 1'b1, 1'b1, 1'b1, 20'h77777, "R6");
      do_probe(20'h00300, 8'd0, "R6");

      // R10: misaligned fetch
      do_lookup({20'h00100, 12'h001}, 8'd3, 1'b1, "R10");
      do_lookup({20'h00100, 12'h002}, 8'd3, 1'b1, "R10");
      do_lookup({20'h00100, 12'h004}, 8'd3, 1'b1, "R10");
      do_lookup({20'h00100, 12'h003}, 8'd3, 1'b0, "R10");

      // R11: uncacheable window
      do_lookup(32'hA000_0000, 8'd0, 1'b0, "R11");
      do_lookup(32'h8000_0000, 8'd0, 1'b0, "R11");
      do_lookup(32'h2000_0000, 8'd0, 1'b0, "R11");
      do_lookup(32'hB000_1234, 8'd0, 1'b0, "R11");

      // R8, R9: pointer read, advance and wrap
      do_read(1'b0, "R8");
      do_read(1'b0, "R8");
      for (int k = 0; k < N; k++) do_read(1'b1, "R8");
      do_read(1'b0, "R9");
      do_read(1'b1, "R8");
      do_read(1'b1, "R8");

      // R7: flush
      do_flush();
      do_read(1'b0, "R7");
      do_probe(20'h00100, 8'd3, "R7");
      do_lookup({20'h00040, 12'h000}, 8'd1, 1'b0, "R7");

      // Random traffic
      for (int it = 0; it < 600; it++) begin
         int op;
         logic [19:0] mask;
         logic v0, v1;
         op = $urandom % 20;
         if (op < 7) begin
            case ($urandom % 4)
               0: mask = 20'h00003;
               1: mask = 20'h00001;
               default: mask = 20'h0;
            endcase
            v0 = ($urandom % 3) != 0;
            v1 = ($urandom % 4) == 0;
            do_write(4'($urandom % 10), pick_vpn(), mask, 8'($urandom % 4),
                     ($urandom % 5) == 0, v0, v1, 20'($urandom), "R6");
         end else if (op < 13) begin
            do_lookup({pick_vpn(), 12'($urandom)}, 8'($urandom % 4),
                      1'($urandom % 2), "R3");
         end else if (op < 17) begin
            do_probe(pick_vpn(), 8'($urandom % 4), "R4");
         end else if (op < 19) begin
            do_read(1'($urandom % 2), "R8");
         end else begin
            do_flush();
            do_read(1'b0, "R7");
         end
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

endmodule